// File: doc/BRIEF.md
# Smooth Clock Calibration Pulse Masker

This block trims the long-run rate of a slow (32.768 kHz-class) clock. Each slow-clock cycle normally yields one enable for the prescaler chain that follows. Over a calibration window of selectable length the block either drops a programmed number of those enables or adds extra ones. The dropped and added pulses are spread evenly over the window rather than bunched together. The net number of pulses added per full-length window is 512 when the increase flag is set, minus the programmed mask count. One pulse per full-length window is about 0.95 ppm, so the reachable range is roughly -487 ppm to +488 ppm.

Software writes a 9-bit mask count, an increase flag and a window select together with a write strobe. The write only stages the values and raises a pending flag. The staged values take over at the next window boundary, and the pending flag then drops. A separate flag warns when a positive correction is active while the asynchronous prescaler value is below 3. In that case the synchronous prescaler has to be reduced, and the block leaves that to the software.

The window counter runs for 2^CNT_W slow-clock cycles, 2^20 by default. A correction slot occurs every 2^(CNT_W-9) cycles. The shorter windows keep the same slot spacing and ignore the low bits of the mask count.

Top module: `smooth_cal_masker`

## Requirements
- R1: While reset is held and right after it, the active correction is zero (mask 0, increase flag 0, longest window). cal_en is 1, and cal_extra, cal_pend and cal_conflict are 0.
- R2: The window lasts 2^CNT_W cycles for cfg_wsel = 2'b00, 2^(CNT_W-1) cycles for 2'b01, and 2^(CNT_W-2) cycles for 2'b10 or 2'b11 (bit 1 takes priority).
- R3: The number of slots masked per window equals the mask count shifted right by s. Here s is 0, 1 or 2 for the long, middle and short window.
- R4: Slots fall on window-counter values that are multiples of 2^(CNT_W-9), and the slot number is k = counter >> (CNT_W-9). Slot k is masked when the 9-bit bit-reversal of k is less than the mask count with its s low bits cleared.
- R5: With the increase flag active, every slot that is not masked gives cal_en = 1 and cal_extra = 1. The net count per window, (cal_extra ones) minus (cal_en zeros), equals flag*(512>>s) - (mask>>s).
- R6: A slot that is both masked and carries an insertion gives cal_en = 1 and cal_extra = 0, so the two cancel.
- R7: A cfg_wr pulse sets cal_pend in the next cycle. The active settings stay unchanged until the last cycle of the current window. The staged values govern from the following cycle, and cal_pend clears then unless another write occurs.
- R8: A cfg_wr in the last cycle of a window stages the new values for the window after next. The window that starts next uses the previously staged values, and cal_pend stays 1.
- R9: cal_conflict is 1 exactly when the active increase flag is set and apre_val is less than 3.
- R10: In every non-slot cycle, cal_en is 1 and cal_extra is 0, whatever the settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow clock being calibrated |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe that stages the settings below |
| cfg_incr | input | 1 | Increase flag: add 512>>s pulses per window |
| cfg_wsel | input | 2 | Window select: 00 long, 01 half, 1x quarter |
| cfg_mask | input | 9 | Pulses to mask per long window |
| apre_val | input | APRE_W | Asynchronous prescaler value, used for the conflict flag |
| cal_en | output | 1 | Prescaler enable for this cycle (0 = pulse swallowed) |
| cal_extra | output | 1 | Second prescaler enable for this cycle (inserted pulse) |
| cal_pend | output | 1 | Staged settings not yet applied |
| cal_conflict | output | 1 | Positive correction active with apre_val below 3 |

## Verification
Masking and insertion can land on the same slot, and the bench provokes this by running the increase flag with a nonzero mask count. Every slot then carries an insertion, and the slots whose reversed index falls below the mask count are also masked. The bench judges each such cycle against a reference that expects cal_en high with cal_extra low. It also checks that no enable is lost over a whole window and that the net count comes to 512 minus the mask count. A second collision, a settings write landing in the window's last cycle, is provoked by timing the strobe from the bench's own window model and judged on cal_pend and on the mask counts of the next two windows.

// File: rtl/scm_pkg.sv
package scm_pkg;

  parameter int unsigned CAL_MASK_W = 9;

  typedef struct packed {
    logic                  incr;
    logic [1:0]            wsel;
    logic [CAL_MASK_W-1:0] mask;
  } cal_cfg_t;

  // Number of halvings of the window; bit 1 of the select has priority
  function automatic logic [1:0] win_shift(input logic [1:0] wsel);
    if (wsel[1])      return 2'd2;
    else if (wsel[0]) return 2'd1;
    else              return 2'd0;
  endfunction

  function automatic logic [CAL_MASK_W-1:0] bit_rev(input logic [CAL_MASK_W-1:0] v);
    logic [CAL_MASK_W-1:0] r;
    for (int i = 0; i < CAL_MASK_W; i++) r[i] = v[CAL_MASK_W-1-i];
    return r;
  endfunction

endpackage

// File: rtl/scm_cfg_stage.sv
module scm_cfg_stage
  import scm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_stb,
  input  cal_cfg_t cfg_in,
  input  logic     win_end,
  output cal_cfg_t cfg_act,
  output logic     pend
);

  cal_cfg_t stg_q, stg_d;
  cal_cfg_t act_q, act_d;
  logic     pend_q, pend_d;

  always_comb begin
    stg_d  = stg_q;
    act_d  = act_q;
    pend_d = pend_q;
    if (wr_stb)  stg_d = cfg_in;
    if (win_end) act_d = stg_q;
    if (wr_stb)       pend_d = 1'b1;
    else if (win_end) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      act_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      stg_q  <= stg_d;
      act_q  <= act_d;
      pend_q <= pend_d;
    end
  end

  assign cfg_act = act_q;
  assign pend    = pend_q;

  // R7
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(act_q));

  // R7
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> $past(win_end) && !$past(wr_stb));

  // R8
  wr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> pend_q);

endmodule

// File: rtl/scm_window_ctr.sv
module scm_window_ctr
  import scm_pkg::*;
#(
  parameter int unsigned CNT_W = 20
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            wsel,
  output logic                  win_end,
  output logic                  slot_hit,
  output logic [CAL_MASK_W-1:0] slot_idx
);

  localparam int unsigned SLOT_W = CNT_W - CAL_MASK_W;

  logic [CNT_W-1:0] ctr_q, ctr_d, last_val;

  always_comb begin
    last_val = {CNT_W{1'b1}} >> win_shift(wsel);
    win_end  = (ctr_q >= last_val);
    ctr_d    = win_end ? '0 : ctr_q + CNT_W'(1);
    slot_hit = (ctr_q[SLOT_W-1:0] == '0);
    slot_idx = ctr_q[CNT_W-1:SLOT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctr_q <= '0;
    else        ctr_q <= ctr_d;
  end

  // R2
  ctr_in_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_q <= last_val);

  // R2
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (ctr_q == '0));

endmodule

// File: rtl/scm_pulse_gate.sv
module scm_pulse_gate
  import scm_pkg::*;
(
  input  logic                  slot_hit,
  input  logic [CAL_MASK_W-1:0] slot_idx,
  input  cal_cfg_t              cfg,
  output logic                  pulse_en,
  output logic                  pulse_extra
);

  logic [CAL_MASK_W-1:0] mask_eff;
  logic                  hit_mask;
  logic                  hit_ins;

  always_comb begin
    mask_eff    = cfg.mask & ({CAL_MASK_W{1'b1}} << win_shift(cfg.wsel));
    hit_mask    = slot_hit && (bit_rev(slot_idx) < mask_eff);
    hit_ins     = slot_hit && cfg.incr;
    pulse_en    = !hit_mask || hit_ins;
    pulse_extra = hit_ins && !hit_mask;
  end

endmodule

// File: rtl/smooth_cal_masker.sv
module smooth_cal_masker
  import scm_pkg::*;
#(
  parameter int unsigned CNT_W    = 20,
  parameter int unsigned APRE_W   = 7,
  parameter int unsigned APRE_MIN = 3
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic                  cfg_incr,
  input  logic [1:0]            cfg_wsel,
  input  logic [CAL_MASK_W-1:0] cfg_mask,
  input  logic [APRE_W-1:0]     apre_val,
  output logic                  cal_en,
  output logic                  cal_extra,
  output logic                  cal_pend,
  output logic                  cal_conflict
);

  cal_cfg_t              cfg_wr_val;
  cal_cfg_t              cfg_act;
  logic                  win_end;
  logic                  slot_hit;
  logic [CAL_MASK_W-1:0] slot_idx;

  assign cfg_wr_val = '{incr: cfg_incr, wsel: cfg_wsel, mask: cfg_mask};

  scm_cfg_stage u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (cfg_wr),
    .cfg_in  (cfg_wr_val),
    .win_end (win_end),
    .cfg_act (cfg_act),
    .pend    (cal_pend)
  );

  scm_window_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wsel     (cfg_act.wsel),
    .win_end  (win_end),
    .slot_hit (slot_hit),
    .slot_idx (slot_idx)
  );

  scm_pulse_gate u_gate (
    .slot_hit    (slot_hit),
    .slot_idx    (slot_idx),
    .cfg         (cfg_act),
    .pulse_en    (cal_en),
    .pulse_extra (cal_extra)
  );

  assign cal_conflict = cfg_act.incr && (apre_val < APRE_W'(APRE_MIN));

  // R10
  off_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_hit |-> (cal_en && !cal_extra));

  // R6
  no_loss_and_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_en |-> !cal_extra);

  // R5
  extra_needs_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_extra |-> cfg_act.incr);

  // R9
  conflict_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_conflict |-> cfg_act.incr);

endmodule

// File: tb/test_smooth_cal_masker.sv
module test_smooth_cal_masker;

  localparam int CLK_P  = 10;
  localparam int CNT_W  = 12;
  localparam int SLOT_W = CNT_W - 9;
  localparam int WD_CYC = 190000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr;
  logic       cfg_incr;
  logic [1:0] cfg_wsel;
  logic [8:0] cfg_mask;
  logic [6:0] apre_val;
  logic       cal_en, cal_extra, cal_pend, cal_conflict;

  always #(CLK_P/2) clk = ~clk;

  smooth_cal_masker #(.CNT_W(CNT_W), .APRE_W(7), .APRE_MIN(3)) i_smooth_cal_masker (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_incr(cfg_incr),
    .cfg_wsel(cfg_wsel), .cfg_mask(cfg_mask), .apre_val(apre_val),
    .cal_en(cal_en), .cal_extra(cal_extra), .cal_pend(cal_pend),
    .cal_conflict(cal_conflict)
  );

  typedef struct {
    logic  en;
    logic  extra;
    logic  pend;
    logic  conf;
    logic  slot;
    string ptag;
  } exp_t;

  exp_t q[$];

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference model state
  int m_ctr;
  int a_incr, a_sel, a_mask;
  int s_incr, s_sel, s_mask;
  int m_pend;
  // next input values
  int nx_incr, nx_sel, nx_mask, nx_apre;
  string pend_tag = "R7";

  // monitor accumulators
  int acc_zero, acc_extra;
  int cyc;
  int last_mask_cyc;
  int mask_period;

  function automatic int shf(input int sel);
    if ((sel & 2) != 0) return 2;
    if ((sel & 1) != 0) return 1;
    return 0;
  endfunction

  function automatic int mlast(input int sel);
    return (1 << (CNT_W - shf(sel))) - 1;
  endfunction

  function automatic int rev9(input int v);
    int r = 0;
    for (int i = 0; i < 9; i++) if (((v >> i) & 1) != 0) r |= 1 << (8 - i);
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // driver: called at a falling edge; pushes the expected item, then advances the model
  task automatic step(input bit w);
    exp_t e;
    int   sh, meff, k;
    bit   slot, msk, ins, bnd;
    cfg_wr   = w;
    cfg_incr = nx_incr[0];
    cfg_wsel = nx_sel[1:0];
    cfg_mask = nx_mask[8:0];
    apre_val = nx_apre[6:0];
    sh   = shf(a_sel);
    meff = a_mask & ((511 << sh) & 511);
    slot = (m_ctr % (1 << SLOT_W)) == 0;
    k    = m_ctr >> SLOT_W;
    msk  = slot && (rev9(k) < meff);
    ins  = slot && (a_incr != 0);
    e.en    = !(msk && !ins);
    e.extra = ins && !msk;
    e.pend  = (m_pend != 0);
    e.conf  = (a_incr != 0) && (nx_apre < 3);
    e.slot  = slot;
    e.ptag  = pend_tag;
    q.push_back(e);
    @(posedge clk);
    bnd = (m_ctr == mlast(a_sel));
    if (bnd) begin
      a_incr = s_incr; a_sel = s_sel; a_mask = s_mask;
      m_ctr  = 0;
    end else begin
      m_ctr++;
    end
    if (w) begin
      s_incr = nx_incr; s_sel = nx_sel; s_mask = nx_mask;
      m_pend = 1;
    end else if (bnd) begin
      m_pend = 0;
    end
    @(negedge clk);
  endtask

  task automatic write_cfg(input int incr, input int sel, input int mask);
    nx_incr = incr; nx_sel = sel; nx_mask = mask;
    step(1'b1);
  endtask

  // run until the staged settings are active and a window is just starting
  task automatic sync_window();
    while (m_pend != 0 || m_ctr != 0) step(1'b0);
  endtask

  task automatic measure_window(input int exp_net, input string tag);
    int n;
    n = mlast(a_sel) + 1;
    acc_zero  = 0;
    acc_extra = 0;
    repeat (n) step(1'b0);
    chk((acc_extra - acc_zero) == exp_net, tag, acc_extra - acc_zero, exp_net);
  endtask

  // monitor: pops the expected item and compares away from the clock edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        cyc++;
        if (!cal_en) begin
          acc_zero++;
          if (last_mask_cyc >= 0) mask_period = cyc - last_mask_cyc;
          last_mask_cyc = cyc;
        end
        if (cal_extra) acc_extra++;
        chk(cal_en == e.en, e.slot ? "R4 cal_en at slot" : "R10 cal_en off slot",
            int'(cal_en), int'(e.en));
        chk(cal_extra == e.extra, e.slot ? "R5 cal_extra at slot" : "R10 cal_extra off slot",
            int'(cal_extra), int'(e.extra));
        chk(cal_pend == e.pend, {e.ptag, " cal_pend"}, int'(cal_pend), int'(e.pend));
        chk(cal_conflict == e.conf, "R9 cal_conflict", int'(cal_conflict), int'(e.conf));
      end
    end
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=%0d expected=%0d", WD_CYC, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    cfg_wr = 1'b0; cfg_incr = 1'b0; cfg_wsel = 2'b00; cfg_mask = '0; apre_val = '0;
    m_ctr = 0; a_incr = 0; a_sel = 0; a_mask = 0; s_incr = 0; s_sel = 0; s_mask = 0;
    m_pend = 0; nx_incr = 0; nx_sel = 0; nx_mask = 0; nx_apre = 0;
    acc_zero = 0; acc_extra = 0; cyc = 0; last_mask_cyc = -1; mask_period = 0;

    repeat (2) @(negedge clk);
    // R1 reset state
    chk(cal_en == 1'b1,       "R1 cal_en in reset",       int'(cal_en), 1);
    chk(cal_extra == 1'b0,    "R1 cal_extra in reset",    int'(cal_extra), 0);
    chk(cal_pend == 1'b0,     "R1 cal_pend in reset",     int'(cal_pend), 0);
    chk(cal_conflict == 1'b0, "R1 cal_conflict in reset", int'(cal_conflict), 0);
    rst_n = 1'b1;

    // R1 zero correction after reset
    measure_window(0, "R1 net after reset");

    // R3 R2: one mask per long window, period equals the window
    write_cfg(0, 0, 1);
    sync_window();
    last_mask_cyc = -1;
    measure_window(-1, "R3 mask 1 long");
    measure_window(-1, "R3 mask 1 long again");
    chk(mask_period == 4096, "R2 long window period", mask_period, 4096);

    // R3 R4: dense masking
    write_cfg(0, 0, 300);
    sync_window();
    measure_window(-300, "R3 mask 300 long");

    // R5: maximum positive correction
    write_cfg(1, 0, 0);
    sync_window();
    measure_window(512, "R5 incr mask 0 long");

    // R6: insertion and masking on the same slots
    write_cfg(1, 0, 100);
    sync_window();
    measure_window(412, "R6 incr mask 100 net");
    chk(acc_zero == 0, "R6 no swallowed enable", acc_zero, 0);

    // R9: conflict with low prescaler value, then cleared
    nx_apre = 2;
    repeat (20) step(1'b0);
    nx_apre = 3;
    repeat (20) step(1'b0);
    nx_apre = 0;

    // R3: half window drops the low mask bit
    write_cfg(0, 1, 301);
    sync_window();
    measure_window(-150, "R3 mask 301 half");

    // R2: half window period
    write_cfg(0, 1, 2);
    sync_window();
    last_mask_cyc = -1;
    measure_window(-1, "R3 mask 2 half");
    measure_window(-1, "R3 mask 2 half again");
    chk(mask_period == 2048, "R2 half window period", mask_period, 2048);

    // R3: quarter window drops two low bits
    write_cfg(0, 2, 511);
    sync_window();
    measure_window(-127, "R3 mask 511 quarter");

    // R2: select 11 behaves as quarter window
    write_cfg(0, 3, 4);
    sync_window();
    last_mask_cyc = -1;
    measure_window(-1, "R2 sel 11 mask 4");
    measure_window(-1, "R2 sel 11 mask 4 again");
    chk(mask_period == 1024, "R2 quarter window period", mask_period, 1024);

    // R5: positive correction scaled to the quarter window
    write_cfg(1, 2, 0);
    sync_window();
    measure_window(128, "R5 incr quarter");

    // R8: write landing in the last cycle of a window
    write_cfg(0, 0, 0);
    sync_window();
    write_cfg(0, 0, 7);
    while (m_ctr != mlast(a_sel)) step(1'b0);
    pend_tag = "R8";
    write_cfg(0, 0, 20);
    measure_window(-7, "R8 previous staged value applied");
    pend_tag = "R7";
    measure_window(-20, "R8 late write applied one window later");

    finish_run();
  end

endmodule